// File: doc/BRIEF.md
# Sigma-Delta Interrupt Flag Aggregator

This block holds the interrupt flags of a four-channel sigma-delta filter unit and combines them into one interrupt request. Each channel has six event inputs: FIFO data ready, FIFO overflow, filter acknowledge, modulator failure, and two comparator events. A one-cycle pulse on any of these inputs latches the matching flag. Software reads the flags at one bus address. It removes flags by writing ones to a separate clear address.

A master flag summarises the enabled flags and drives an active-low interrupt output. Only the master's own clear bit can clear the master flag. If an enabled flag is still pending when software clears the master, the master sets again on the next clock. The interrupt output then gives a fresh low pulse, so no pending event goes unnoticed.

The bus is a plain register port: write strobe, address, write data and combinational read data. A per-flag enable vector decides which flags may raise the master flag.

Top module: `sdf_irq_flags`

## Requirements
- R1: A write to the clear address (address 1) with bit i of the data at 1 clears flag i on that clock edge. A data bit at 0 leaves its flag unchanged.
- R2: If an event sets flag i on the same edge that a clear write hits bit i, the flag ends at 1.
- R3: The flag and clear bit layout for channel c (0..3) is as follows. Comparator event 1 is bit 2c and comparator event 2 is bit 2c+1. Modulator failure is bit 8+c, acknowledge is bit 12+c, FIFO overflow is bit 16+c and FIFO data ready is bit 20+c. The master flag is bit 31.
- R4: After reset, every flag and the master flag are 0 and `irq_n` is 1.
- R5: Reading the clear address returns 0. A write to the flag address (address 0) changes no flag, and neither does any write to another address.
- R6: When an event newly sets a flag whose `flag_en` bit is 1, the master flag is 1 after that edge. A flag whose enable bit is 0 still latches but does not set the master flag.
- R7: Clearing individual flags does not clear the master flag. Only a clear write with bit 31 at 1 does.
- R8: If a clear write with bit 31 at 1 clears the master flag while an enabled flag is still set after that edge, the master flag reads 0 for one cycle and is 1 again after the next edge.
- R9: Each time the master flag goes from 0 to 1, `irq_n` is 0 for exactly one clock cycle, in the cycle after that edge. Otherwise `irq_n` stays 1.
- R10: Bits 30:24 of the flag address read as 0. Writing ones to those bits of the clear address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address: 0 is the flags, 1 is the clear register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| flag_en | input | 24 | Per-flag enable toward the master flag |
| ev_drdy | input | 4 | FIFO data-ready events, one bit per channel |
| ev_ovf | input | 4 | FIFO overflow events |
| ev_ack | input | 4 | Filter acknowledge events |
| ev_modf | input | 4 | Modulator failure events |
| ev_cmp1 | input | 4 | Comparator event 1 |
| ev_cmp2 | input | 4 | Comparator event 2 |
| irq_n | output | 1 | Active-low interrupt pulse |

## Verification
Assertions check on every cycle that a set event beats a clear, that a clear with no competing set takes effect, that the interrupt pulse lasts one cycle, and that every rise of the master flag comes with a pulse. They also check that a master clear with enabled flags still pending is followed by a re-set, and that the clear address reads zero. Some behaviour only the bench's scenarios can show. These are the exact bit placement of every event, disabled flags that latch without interrupting, and master-only clears with nothing pending. The bench also checks that individual clears leave the master flag standing. It compares each of these against a behavioural model on every clock.

// File: rtl/sdf_irq_flags.sv
module sdf_irq_flags #(
  parameter int NCH = 4,
  parameter int AW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [6*NCH-1:0]  flag_en,
  input  logic [NCH-1:0]    ev_drdy,
  input  logic [NCH-1:0]    ev_ovf,
  input  logic [NCH-1:0]    ev_ack,
  input  logic [NCH-1:0]    ev_modf,
  input  logic [NCH-1:0]    ev_cmp1,
  input  logic [NCH-1:0]    ev_cmp2,
  output logic              irq_n
);
  localparam int FW   = 6*NCH;
  localparam int DW   = 32;
  localparam int MBIT = DW-1;
  localparam logic [AW-1:0] FLAG_ADDR = AW'(0);
  localparam logic [AW-1:0] CLR_ADDR  = AW'(1);

  logic [FW-1:0] set_v, clr_v, flag_q, flag_d;
  logic m_q, m_d, m_set, m_clr, clr_pend_q, irq_q, clr_hit, new_rise, rearm;
  logic unused_wbits;

  for (genvar c = 0; c < NCH; c++) begin : g_map
    assign set_v[2*c]       = ev_cmp1[c];
    assign set_v[2*c+1]     = ev_cmp2[c];
    assign set_v[2*NCH+c]   = ev_modf[c];
    assign set_v[3*NCH+c]   = ev_ack[c];
    assign set_v[4*NCH+c]   = ev_ovf[c];
    assign set_v[5*NCH+c]   = ev_drdy[c];
  end

  assign clr_hit  = bus_we && (bus_addr == CLR_ADDR);
  assign clr_v    = clr_hit ? bus_wdata[FW-1:0] : '0;
  assign m_clr    = clr_hit && bus_wdata[MBIT];
  assign new_rise = |(set_v & ~flag_q & flag_en);
  assign rearm    = clr_pend_q && |(flag_q & flag_en);
  assign m_set    = new_rise || rearm;
  assign m_d      = m_set || (m_q && !m_clr);
  assign flag_d   = set_v | (flag_q & ~clr_v);
  assign unused_wbits = &{1'b0, bus_wdata[MBIT-1:FW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q     <= '0;
      m_q        <= 1'b0;
      clr_pend_q <= 1'b0;
      irq_q      <= 1'b1;
    end else begin
      flag_q     <= flag_d;
      m_q        <= m_d;
      clr_pend_q <= m_clr && m_q && !m_set;
      irq_q      <= !(m_set && !m_q);
    end
  end

  assign irq_n     = irq_q;
  assign bus_rdata = (bus_addr == FLAG_ADDR) ? {m_q, {(DW-1-FW){1'b0}}, flag_q} : '0;

  for (genvar i = 0; i < FW; i++) begin : g_chk
    a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[i] |=> flag_q[i]);
    a_r1_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[i] && !set_v[i]) |=> !flag_q[i]);
  end

  a_r9_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |=> irq_n);
  a_r9_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_q) |-> !irq_n);
  a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (m_q && m_clr && !new_rise && |(flag_d & flag_en)) |=> (!m_q ##1 m_q));
  a_r5_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CLR_ADDR) |-> (bus_rdata == '0));
endmodule

// File: tb/sdf_irq_flags_test.sv
`timescale 1ns/1ps
module sdf_irq_flags_test;
  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [23:0] flag_en = '1;
  logic [3:0] ev_drdy = 0, ev_ovf = 0, ev_ack = 0, ev_modf = 0, ev_cmp1 = 0, ev_cmp2 = 0;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 0;
  string req = "R4";

  logic [23:0] mf = 0;
  logic mm = 0, mpend = 0, mirq = 1;

  always #2.5 clk = ~clk;

  sdf_irq_flags uut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flag_en(flag_en), .ev_drdy(ev_drdy),
    .ev_ovf(ev_ovf), .ev_ack(ev_ack), .ev_modf(ev_modf), .ev_cmp1(ev_cmp1),
    .ev_cmp2(ev_cmp2), .irq_n(irq_n));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] wd, input logic [23:0] ev);
    logic [23:0] clrv, nf;
    logic rise, rearm, nm;
    bus_we = we; bus_addr = a; bus_wdata = wd;
    for (int c = 0; c < 4; c++) begin
      ev_cmp1[c] = ev[2*c]; ev_cmp2[c] = ev[2*c+1]; ev_modf[c] = ev[8+c];
      ev_ack[c] = ev[12+c]; ev_ovf[c] = ev[16+c]; ev_drdy[c] = ev[20+c];
    end
    @(posedge clk);
    clrv = (we && a == 2'd1) ? wd[23:0] : 24'h0;
    rise = 0; rearm = 0;
    for (int i = 0; i < 24; i++) begin
      if (ev[i] && !mf[i] && flag_en[i]) rise = 1;
      if (mpend && mf[i] && flag_en[i]) rearm = 1;
      nf[i] = ev[i] ? 1'b1 : (clrv[i] ? 1'b0 : mf[i]);
    end
    if (rise || rearm) nm = 1;
    else if (we && a == 2'd1 && wd[31]) nm = 0;
    else nm = mm;
    mpend = we && a == 2'd1 && wd[31] && mm && !(rise || rearm);
    mirq = !(nm && !mm);
    mm = nm; mf = nf;
    @(negedge clk);
    chk({req, " rdata"}, bus_rdata, (bus_addr == 2'd0) ? {mm, 7'b0, mf} : 32'h0);
    chk({req, " irq_n"}, {31'b0, irq_n}, {31'b0, mirq});
    bus_we = 0; ev_cmp1 = 0; ev_cmp2 = 0; ev_modf = 0; ev_ack = 0; ev_ovf = 0; ev_drdy = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 2'd0, 0, 0);
  endtask

  task automatic clr(input logic [31:0] v);
    step(1, 2'd1, v, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R4";
    chk("R4 reset rdata", bus_rdata, 32'h0);
    chk("R4 reset irq_n", {31'b0, irq_n}, 32'h1);
    rst_n = 1;
    idle(2);

    req = "R3";
    for (int i = 0; i < 24; i++) begin
      step(0, 2'd0, 0, 24'h1 << i);
      chk("R3 bit placement", bus_rdata, 32'h8000_0000 | (32'h1 << i));
      chk("R9 pulse low", {31'b0, irq_n}, 32'h0);
      idle(1);
      chk("R9 pulse ends", {31'b0, irq_n}, 32'h1);
      req = "R7";
      clr(32'h1 << i);
      step(0, 2'd0, 0, 0);
      chk("R7 master stays", bus_rdata, 32'h8000_0000);
      clr(32'h8000_0000);
      idle(2);
      chk("R7 master cleared", bus_rdata, 32'h0);
      req = "R3";
    end

    req = "R1";
    step(0, 2'd0, 0, 24'h00_0F0F);
    clr(32'h0);
    idle(1);
    chk("R1 write zero keeps", bus_rdata, 32'h8000_0F0F);
    clr(32'h0000_0A05);
    idle(1);
    chk("R1 partial clear", bus_rdata, 32'h8000_050A);

    req = "R5";
    step(1, 2'd0, 32'hFFFF_FFFF, 0);
    step(1, 2'd2, 32'hFFFF_FFFF, 0);
    step(1, 2'd3, 32'hFFFF_FFFF, 0);
    idle(1);
    chk("R5 flag addr ignored", bus_rdata, 32'h8000_050A);
    step(0, 2'd1, 0, 0);
    chk("R5 clear reads zero", bus_rdata, 32'h0);

    req = "R2";
    step(1, 2'd1, 32'h0000_0F0F, 24'h00_0001);
    idle(1);
    chk("R2 set beats clear", bus_rdata, 32'h8000_0001);

    req = "R8";
    clr(32'h8000_0000);
    chk("R8 master low one cycle", bus_rdata, 32'h0);
    step(0, 2'd0, 0, 0);
    chk("R8 master back", bus_rdata, 32'h8000_0001);
    chk("R8 re-pulse", {31'b0, irq_n}, 32'h0);
    idle(1);
    clr(32'h8000_0001);
    idle(2);
    chk("R8 no rearm when empty", bus_rdata, 32'h0);

    req = "R6";
    flag_en = 24'hFF_FFFE;
    step(0, 2'd0, 0, 24'h00_0001);
    chk("R6 disabled latches only", bus_rdata, 32'h0000_0001);
    chk("R6 no pulse", {31'b0, irq_n}, 32'h1);
    step(0, 2'd0, 0, 24'h80_0000);
    chk("R6 enabled sets master", bus_rdata, 32'h8080_0001);
    clr(32'h8080_0000);
    idle(2);
    chk("R6 disabled no rearm", bus_rdata, 32'h0000_0001);
    flag_en = '1;

    req = "R10";
    clr(32'h7F00_0000);
    idle(1);
    chk("R10 reserved ignored", bus_rdata, 32'h0000_0001);
    clr(32'h00FF_FFFF);
    idle(1);
    chk("R10 reserved read zero", bus_rdata & 32'h7F00_0000, 32'h0);

    req = "R9";
    step(0, 2'd0, 0, 24'h10_0000);
    step(0, 2'd0, 0, 24'h20_0000);
    chk("R9 no pulse while set", {31'b0, irq_n}, 32'h1);
    idle(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule